// File: doc/BRIEF.md
# Selectable Clock-Synchronous Serial Transceiver

This block moves bytes in and out over a serial link whose clock comes from an external master. Bits go out on the data output and are captured from the data input, least significant bit first. A register-style write port sets the enables and loads transmit data. Another write to the same port clears the sticky receive flags. A six-bit status word and the last received byte are always visible at the outputs.

An optional select input lets one master share its clock and data wires among several of these units. When the select feature is enabled and the select input is high (not selected), two things happen. The data output is released to high impedance, and the incoming clock is seen internally as a constant high, so no bit moves. The serial clock, the select input and the serial data input are synchronised into the system clock with two-flop stages, and clock edges are detected in that domain. Transmit and receive must be enabled together in one write when moving to full duplex. A write that adds the second enable while the first is already on is refused.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the status word reads 6'b000011: bit0 transmit-buffer-empty = 1, bit1 transmit-end = 1, and bits 2 to 5 (receive-full, overrun, framing, parity) = 0. The control readback is 0 and the output enable is 0.
- R2: A write to address 0 loads bit0 = transmit enable, bit1 = receive enable and bit2 = select enable. A write that turns on one of the two enables while the other is already on leaves both enables unchanged.
- R3: While the select enable is 1 and the select input is high, the data output enable is 0.
- R4: While deselected, clock pin activity shifts nothing. No byte is received, and after reselection the next eight clocks form a whole byte.
- R5: Transmit data leaves least significant bit first. Each bit is updated after a falling clock edge and is stable when the following rising edge arrives. The first falling edge with data pending starts the frame.
- R6: Receive data is sampled on rising clock edges, least significant bit first. The eighth rising edge places the byte on the receive data output and sets receive-full (status bit2).
- R7: A write to address 1 loads the transmit byte and clears transmit-empty and transmit-end. Frame start sets transmit-empty again. Transmit-end is set when the eighth bit finishes with nothing pending. Transmit-end = 1 implies transmit-empty = 1.
- R8: If a byte completes while receive-full is set, overrun (status bit3) is set and the receive data output keeps its old value.
- R9: A write to address 2 clears each of status bits 2 to 5 whose matching data bit is 1.
- R10: Framing (status bit4) and parity (status bit5) errors never become 1 in this synchronous mode.
- R11: Clearing the transmit enable drops any frame or pending byte, sets transmit-empty and transmit-end, and turns the output enable off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 transmit data, 2 flag clear |
| wr_data_i | input | 8 | Register write data |
| sck_i | input | 1 | Serial clock from the master |
| sel_n_i | input | 1 | Select input, high = not selected |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Serial data output enable (0 = high impedance) |
| ctrl_o | output | 3 | Control readback {select enable, receive enable, transmit enable} |
| status_o | output | 6 | Status flags, bit0 to bit5 as in R1 |
| rx_data_o | output | 8 | Last received byte |

## Verification
The bench tries to add the receive enable on top of a running transmit enable. A design that lacked the refusal would turn on full duplex there, which the control readback exposes. It sends a second byte without clearing receive-full. A design without overrun handling would overwrite the received byte or leave the overrun flag clear. It runs eight clock periods while deselected and then a full byte after reselection. A design that let the gated clock through would set receive-full early, or would misalign the following byte, which shows up as a wrong value. It also compares every transmitted bit at the rising edge, so a reversed bit order or an edge off by one shows as a wrong captured byte.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    parameter int XW      = 8;
    localparam int CNT_W  = $clog2(XW);
    localparam int STAT_W = 6;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TXD  = 2'd1;
    localparam logic [1:0] ADDR_CLR  = 2'd2;

    typedef struct packed {
        logic             te;
        logic             re;
        logic             sel_en;
        logic [XW-1:0]    tdr;
        logic             tdre;
        logic             tend;
        logic [XW-1:0]    tx_sh;
        logic [CNT_W-1:0] tx_cnt;
        logic             tx_act;
        logic             sdo;
        logic [XW-1:0]    rx_sh;
        logic [CNT_W-1:0] rx_cnt;
        logic [XW-1:0]    rdr;
        logic             rdrf;
        logic             orer;
        logic             fer;
        logic             per;
    } xcvr_state_t;
endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q, chain_d;

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_clk_gate.sv
module xcvr_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s_i,
    input  logic desel_i,
    output logic rise_o,
    output logic fall_o
);
    logic sck_int;
    logic prev_d, prev_q;

    always_comb begin
        sck_int = desel_i ? 1'b1 : sck_s_i;
        prev_d  = sck_int;
        rise_o  = sck_int & ~prev_q;
        fall_o  = ~sck_int & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import xcvr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [XW-1:0]     wr_data_i,
    input  logic              sck_i,
    input  logic              sel_n_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [2:0]        ctrl_o,
    output logic [STAT_W-1:0] status_o,
    output logic [XW-1:0]     rx_data_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(XW - 1);

    logic [2:0] pins_s;
    logic       sck_s, sel_s, sdi_s;
    logic       desel, rise, fall;
    xcvr_state_t d, q;

    xcvr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({sdi_i, sel_n_i, sck_i}),
        .q_o  (pins_s)
    );

    assign sck_s = pins_s[0];
    assign sel_s = pins_s[1];
    assign sdi_s = pins_s[2];
    assign desel = q.sel_en & sel_s;

    xcvr_clk_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_s_i(sck_s),
        .desel_i(desel),
        .rise_o (rise),
        .fall_o (fall)
    );

    always_comb begin
        logic want_te, want_re, refuse;
        logic [XW-1:0] rx_next;
        d       = q;
        want_te = wr_data_i[0];
        want_re = wr_data_i[1];
        refuse  = (want_te & ~q.te & q.re) | (want_re & ~q.re & q.te);
        rx_next = {sdi_s, q.rx_sh[XW-1:1]};

        // transmit path
        if (fall) begin
            if (q.tx_act) begin
                d.sdo = q.tx_sh[0];
            end else if (!q.tdre) begin
                d.tx_sh  = q.tdr;
                d.sdo    = q.tdr[0];
                d.tx_cnt = '0;
                d.tx_act = 1'b1;
                d.tdre   = 1'b1;
                d.tend   = 1'b0;
            end
        end
        if (rise && q.tx_act) begin
            d.tx_sh  = q.tx_sh >> 1;
            d.tx_cnt = q.tx_cnt + 1'b1;
            if (q.tx_cnt == LAST_BIT) begin
                d.tx_act = 1'b0;
                if (q.tdre) d.tend = 1'b1;
            end
        end

        // receive path
        if (!q.re) begin
            d.rx_cnt = '0;
        end else if (rise) begin
            d.rx_sh  = rx_next;
            d.rx_cnt = q.rx_cnt + 1'b1;
            if (q.rx_cnt == LAST_BIT) begin
                if (q.rdrf) d.orer = 1'b1;
                else begin
                    d.rdr  = rx_next;
                    d.rdrf = 1'b1;
                end
            end
        end

        // register writes
        if (wr_en_i) begin
            unique case (wr_addr_i)
                ADDR_CTRL: begin
                    d.sel_en = wr_data_i[2];
                    if (!refuse) begin
                        d.te = want_te;
                        d.re = want_re;
                    end
                end
                ADDR_TXD: begin
                    d.tdr  = wr_data_i;
                    d.tdre = 1'b0;
                    d.tend = 1'b0;
                end
                ADDR_CLR: begin
                    if (wr_data_i[2]) d.rdrf = 1'b0;
                    if (wr_data_i[3]) d.orer = 1'b0;
                    if (wr_data_i[4]) d.fer  = 1'b0;
                    if (wr_data_i[5]) d.per  = 1'b0;
                end
                default: ;
            endcase
        end

        // transmitter held idle while disabled
        if (!d.te) begin
            d.tx_act = 1'b0;
            d.tx_cnt = '0;
            d.tdre   = 1'b1;
            d.tend   = 1'b1;
            d.sdo    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.tdre <= 1'b1;
            q.tend <= 1'b1;
            q.sdo  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sdo_o     = q.sdo;
    assign sdo_oe_o  = q.te & ~desel;
    assign ctrl_o    = {q.sel_en, q.re, q.te};
    assign status_o  = {q.per, q.fer, q.orer, q.rdrf, q.tend, q.tdre};
    assign rx_data_o = q.rdr;
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker
    import xcvr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [1:0]        wr_addr_i,
    input logic [XW-1:0]     wr_data_i,
    input logic              desel,
    input logic              sdo_oe_o,
    input logic [2:0]        ctrl_o,
    input logic [STAT_W-1:0] status_o,
    input logic [XW-1:0]     rx_data_o
);
    // R2
    one_enable_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_CTRL && wr_data_i[1:0] == 2'b11 && ctrl_o[1:0] == 2'b01)
        |=> ctrl_o[1:0] == 2'b01);

    // R3
    desel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desel |-> !sdo_oe_o);

    // R7
    txd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_TXD && ctrl_o[0]) |=> !status_o[0]);

    // R7
    tend_implies_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[1] |-> status_o[0]);

    // R8
    overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[3]) |-> $stable(rx_data_o));

    // R10
    no_frame_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[5:4] == 2'b00);

    // R11
    tx_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[0] |-> (status_o[1:0] == 2'b11 && !sdo_oe_o));
endmodule

bind sync_serial_xcvr xcvr_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .desel    (desel),
    .sdo_oe_o (sdo_oe_o),
    .ctrl_o   (ctrl_o),
    .status_o (status_o),
    .rx_data_o(rx_data_o)
);

// File: tb/tb_sync_serial_xcvr.sv
`timescale 1ns/1ps
module tb_sync_serial_xcvr;
    localparam int HALF = 6;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [1:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic       sck = 1, sel_n = 0, sdi = 1;
    logic       sdo, sdo_oe;
    logic [2:0] ctrl;
    logic [5:0] status;
    logic [7:0] rx_data;

    int tests = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sync_serial_xcvr dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .sck_i(sck), .sel_n_i(sel_n), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .ctrl_o(ctrl), .status_o(status),
        .rx_data_o(rx_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = v;
        @(negedge clk); wr_en = 0;
    endtask

    // master clocks one byte; returns what it captured on sdo at each rising edge
    task automatic xfer(input logic [7:0] tx_to_dut, output logic [7:0] got);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sck = 0; sdi = tx_to_dut[i];
            repeat (HALF) @(negedge clk);
            got[i] = sdo;
            sck = 1;
            repeat (HALF) @(negedge clk);
        end
        repeat (HALF) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(status == 6'b000011, "R1 status", status, 6'b000011);
        chk(ctrl == 3'b000 && sdo_oe == 0, "R1 ctrl/oe", {ctrl, sdo_oe}, 0);
    endtask

    task automatic t_enable_rule;
        wr(2'd0, 8'h01);
        chk(ctrl == 3'b001, "R2 tx enable", ctrl, 3'b001);
        wr(2'd0, 8'h03);
        chk(ctrl == 3'b001, "R2 second enable refused", ctrl, 3'b001);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h03);
        chk(ctrl == 3'b011, "R2 both at once", ctrl, 3'b011);
    endtask

    task automatic t_duplex;
        logic [7:0] got;
        wr(2'd1, 8'hA5);
        chk(status[1:0] == 2'b00, "R7 write clears empty/end", status[1:0], 0);
        xfer(8'h3C, got);
        chk(got == 8'hA5, "R5 tx bit order", got, 8'hA5);
        chk(rx_data == 8'h3C, "R6 rx byte", rx_data, 8'h3C);
        chk(status == 6'b000111, "R7 R6 flags after byte", status, 6'b000111);
    endtask

    task automatic t_overrun;
        logic [7:0] got;
        xfer(8'h81, got);
        chk(rx_data == 8'h3C, "R8 data kept", rx_data, 8'h3C);
        chk(status[3:2] == 2'b11, "R8 overrun set", status[3:2], 2'b11);
        chk(status[5:4] == 2'b00, "R10 no frame/parity", status[5:4], 0);
    endtask

    task automatic t_clear;
        wr(2'd2, 8'h3C);
        chk(status[5:2] == 4'b0000, "R9 flags cleared", status[5:2], 0);
    endtask

    task automatic t_select;
        logic [7:0] got;
        wr(2'd0, 8'h07);
        sel_n = 1;
        repeat (4) @(negedge clk);
        chk(sdo_oe == 0, "R3 deselected floats", sdo_oe, 0);
        xfer(8'hFF, got);
        chk(status[2] == 0, "R4 no rx while deselected", status[2], 0);
        sel_n = 0;
        repeat (4) @(negedge clk);
        chk(sdo_oe == 1, "R3 reselected drives", sdo_oe, 1);
        xfer(8'h5A, got);
        chk(rx_data == 8'h5A && status[2], "R4 aligned after reselect", rx_data, 8'h5A);
    endtask

    task automatic t_disable;
        wr(2'd1, 8'h11);
        chk(status[0] == 0, "R7 pending byte", status[0], 0);
        wr(2'd0, 8'h02);
        chk(status[1:0] == 2'b11 && sdo_oe == 0, "R11 tx off idle", {status[1:0], sdo_oe}, 3'b110);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_enable_rule();
        t_duplex();
        t_overrun();
        t_clear();
        t_select();
        t_disable();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule